// File: doc/BRIEF.md
# Sliding-Window Survivor Traceback

This block is the back end of a soft-decision trellis decoder. It takes one survivor decision vector per trellis step from an add-compare-select array and holds these vectors in a circular store. It recovers the decoded bits one window at a time. For each window it starts a traceback in state 0 at the far end of an acquisition span and walks backwards to the start of the window. Bits met inside the acquisition span are dropped. Bits met inside the window are kept. The kept bits come out in reverse time order, so they are held in a small reorder buffer and then sent forward on a ready/valid stream at one bit per clock.

Window length and acquisition length are given again for each block through a one-word configuration handshake. Both are clamped to a design-time maximum, and that maximum sets the size of the store. The final window of a block may be short. It, and any window whose acquisition span would run past the block, is traced from state 0 after the block's last step. This assumes the encoder was flushed back to state 0. Input with a larger acquisition length gives results closer to unwindowed decoding; about six times the constraint length is enough in practice.

Top module: `survivor_traceback`

## Requirements
- R1: `cfg_ready` is high after reset and whenever no block is in progress. A configuration handshake drops it, and it stays low until the handshake of the block's last output bit; it is high again in the next cycle. The window length is the unsigned value in `cfg_data[31:16]` and the acquisition length is the unsigned value in `cfg_data[15:0]`.
- R2: A window length of 0 is taken as 1. A window length above `MAXW` is taken as `MAXW`. An acquisition length above `MAXW` is taken as `MAXW`; 0 is allowed.
- R3: The state is K-1 bits wide and names the encoder state after a step. Bit s of the decision vector for step t selects the predecessor of state s: the previous state is the current state shifted left by one bit, with that decision bit entering the LSB. The decoded bit of step t is the MSB of the state after step t.
- R4: For a window starting at step b with window length W and acquisition length A, where b+W+A is at most N, the bits of steps b to b+W-1 are those of a traceback that starts in state 0 after step b+W+A-1. Steps from b+W onward are not emitted.
- R5: A block of N decision vectors yields exactly N output bits, in increasing step order, and no bit after them.
- R6: If fewer than W+A steps remain from the window start b, the traceback starts in state 0 after the block's final step N-1. The last window carries N-b bits, which may be fewer than W.
- R7: `out_last` is high with the block's final output bit and with no other bit.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_bit` and `out_last` hold their values into the next cycle, and no bit is lost.
- R9: Within a window, once a bit is taken, the next bit of the same window is valid in the following cycle. With `out_ready` held high, a window drains at one bit per clock.
- R10: `dec_ready` is low while no configuration has been accepted, and it is never high together with `cfg_ready`. Decision vectors offered before configuration are not consumed.
- R11: Blocks may follow each other directly with different configurations. Each block is decoded with its own lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_valid | input | 1 | Configuration word offered |
| cfg_ready | output | 1 | Block idle, configuration taken |
| cfg_data | input | 32 | Window length [31:16], acquisition length [15:0] |
| dec_valid | input | 1 | Decision vector offered |
| dec_ready | output | 1 | Decision vector accepted this cycle if valid |
| dec_data | input | 2**(K-1) | One decision bit per state, bit s for state s |
| dec_last | input | 1 | Marks the block's final step |
| out_valid | output | 1 | Decoded bit available |
| out_ready | input | 1 | Downstream takes the bit |
| out_bit | output | 1 | Decoded bit, forward time order |
| out_last | output | 1 | Final decoded bit of the block |

## Verification
The embedded properties check on every cycle the things that can be stated locally. The output holds steady under backpressure. The two ready signals are never both high. The configuration port closes after a handshake and reopens after the final bit. The stored lengths lie within their clamped range, and `out_last` never appears without valid. Whether the bits are the right ones can only be shown by the bench scenarios. They cover the acquisition discard, the start state at window and block ends, the length of the short final window, the forward order and the exact count. They also cover clamping, one-step blocks, zero acquisition and back-to-back blocks with different lengths. The bench compares these against an independent backward walk over random decision vectors.

// File: rtl/survivor_traceback.sv
module survivor_traceback #(
  parameter int K    = 5,
  parameter int MAXW = 16,
  parameter int CW   = 16
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_valid,
  output logic                cfg_ready,
  input  logic [31:0]         cfg_data,
  input  logic                dec_valid,
  output logic                dec_ready,
  input  logic [2**(K-1)-1:0] dec_data,
  input  logic                dec_last,
  output logic                out_valid,
  input  logic                out_ready,
  output logic                out_bit,
  output logic                out_last
);
  localparam int NS    = 2**(K-1);
  localparam int SW    = K-1;
  localparam int AW    = $clog2(2*MAXW);
  localparam int DEPTH = 2**AW;
  localparam int RW    = $clog2(MAXW);

  typedef enum logic [1:0] {P_IDLE, P_WAIT, P_TB, P_OUT} phase_t;

  phase_t        ph;
  logic [CW-1:0] win_len, acq_len, wr, base, tb_idx, nout, oidx;
  logic [SW-1:0] st;
  logic          got_last, last_win;
  logic [NS-1:0] mem [DEPTH];
  logic          rbuf [MAXW];

  wire [15:0]    raw_w = cfg_data[31:16];
  wire [15:0]    raw_a = cfg_data[15:0];
  wire [CW-1:0]  cl_w  = (raw_w == 16'd0) ? CW'(1) :
                         (raw_w > 16'(MAXW)) ? CW'(MAXW) : CW'(raw_w);
  wire [CW-1:0]  cl_a  = (raw_a > 16'(MAXW)) ? CW'(MAXW) : CW'(raw_a);

  wire [CW-1:0]  fill       = wr - base;
  wire [CW-1:0]  span       = win_len + acq_len;
  wire           short_span = got_last && (fill < span);
  wire           final_win  = got_last && (fill <= win_len);
  wire           start_tb   = (ph == P_WAIT) && (got_last || fill >= span);
  wire [CW-1:0]  offs       = tb_idx - base;
  wire           dec_bit    = mem[tb_idx[AW-1:0]][st];
  wire           out_end    = (oidx == nout - CW'(1));

  assign cfg_ready = (ph == P_IDLE);
  assign dec_ready = (ph != P_IDLE) && !got_last && (fill < CW'(DEPTH));
  assign out_valid = (ph == P_OUT);
  assign out_bit   = rbuf[oidx[RW-1:0]];
  assign out_last  = out_valid && last_win && out_end;

  always_ff @(posedge clk)
    if (dec_valid && dec_ready) mem[wr[AW-1:0]] <= dec_data;

  always_ff @(posedge clk)
    if (ph == P_TB && offs < nout) rbuf[offs[RW-1:0]] <= st[SW-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph       <= P_IDLE;
      win_len  <= '0;
      acq_len  <= '0;
      wr       <= '0;
      base     <= '0;
      tb_idx   <= '0;
      nout     <= '0;
      oidx     <= '0;
      st       <= '0;
      got_last <= 1'b0;
      last_win <= 1'b0;
    end else begin
      if (dec_valid && dec_ready) begin
        wr <= wr + CW'(1);
        if (dec_last) got_last <= 1'b1;
      end
      case (ph)
        P_IDLE: if (cfg_valid) begin
          win_len <= cl_w;
          acq_len <= cl_a;
          ph      <= P_WAIT;
        end
        P_WAIT: if (start_tb) begin
          tb_idx   <= short_span ? wr - CW'(1) : base + span - CW'(1);
          nout     <= final_win ? fill : win_len;
          last_win <= final_win;
          st       <= '0;
          ph       <= P_TB;
        end
        P_TB: begin
          st <= {st[SW-2:0], dec_bit};
          if (tb_idx == base) begin
            oidx <= '0;
            ph   <= P_OUT;
          end else begin
            tb_idx <= tb_idx - CW'(1);
          end
        end
        P_OUT: if (out_ready) begin
          if (out_end) begin
            if (last_win) begin
              ph       <= P_IDLE;
              wr       <= '0;
              base     <= '0;
              got_last <= 1'b0;
            end else begin
              base <= base + nout;
              ph   <= P_WAIT;
            end
          end else begin
            oidx <= oidx + CW'(1);
          end
        end
        default: ph <= P_IDLE;
      endcase
    end
  end

  assert_cfg_close_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && cfg_ready |=> !cfg_ready);
  assert_cfg_reopen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> cfg_ready);
  assert_len_clamp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && cfg_ready |=> (win_len != '0) && (win_len <= CW'(MAXW)) && (acq_len <= CW'(MAXW)));
  assert_last_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_bit) && $stable(out_last));
  assert_ready_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_ready && dec_ready));
endmodule

// File: tb/sim_survivor_traceback.sv
module sim_survivor_traceback;
  localparam int K    = 5;
  localparam int MAXW = 16;
  localparam int NS   = 2**(K-1);
  localparam int SW   = K-1;
  localparam int MAXN = 256;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, cfg_valid, cfg_ready, dec_valid, dec_ready, dec_last;
  logic          out_valid, out_ready, out_bit, out_last;
  logic [31:0]   cfg_data;
  logic [NS-1:0] dec_data;

  survivor_traceback #(.K(K), .MAXW(MAXW), .CW(16)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_data(cfg_data),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_data(dec_data), .dec_last(dec_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit), .out_last(out_last));

  int checks = 0;
  int failures = 0;
  logic [NS-1:0] dq [MAXN];
  bit eb [MAXN];
  bit we [MAXN];
  bit fw [MAXN];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R3 convention: predecessor = {state[SW-2:0], decision}, decoded bit = state MSB.
  task automatic build(input int n, input int w, input int a);
    int b;
    int e;
    logic [SW-1:0] st;
    for (int t = 0; t < n; t++) dq[t] = NS'($urandom);
    b = 0;
    while (b < n) begin
      e = (b + w + a < n) ? b + w + a : n;
      st = '0;
      for (int t = e - 1; t >= b; t--) begin
        if (t < b + w) begin
          eb[t] = st[SW-1];
          we[t] = (t == b + w - 1) || (t == n - 1);
          fw[t] = (e == n);
        end
        st = {st[SW-2:0], dq[t][st]};
      end
      b += w;
    end
  endtask

  task automatic run_block(input logic [31:0] word, input int n, input bit rnd, input string ctx);
    int w, a, oi, ii, cyc;
    bit cfg_done, cfg_acc, in_acc, hold, mid, done;
    logic hb, hl;
    w = int'(word[31:16]); a = int'(word[15:0]);
    if (w == 0) w = 1;
    if (w > MAXW) w = MAXW;
    if (a > MAXW) a = MAXW;
    build(n, w, a);
    oi = 0; ii = 0; cyc = 0;
    cfg_done = 0; cfg_acc = 0; in_acc = 0; hold = 0; mid = 0; done = 0;
    hb = 0; hl = 0;
    while (!done) begin
      @(negedge clk);
      cyc++;
      if (cyc > 20000) begin
        chk(0, {"watchdog R5 ", ctx}, oi, n);
        break;
      end
      if (cfg_acc) begin cfg_valid = 0; cfg_done = 1; cfg_acc = 0; end
      else if (!cfg_done) begin cfg_valid = 1; cfg_data = word; end
      if (cfg_valid && cfg_ready) cfg_acc = 1;

      out_ready = rnd ? ($urandom % 3 != 0) : 1'b1;
      if (hold)
        chk(out_valid && out_bit == hb && out_last == hl, {"R8 held output ", ctx},
            {out_valid, out_bit, out_last}, {1'b1, hb, hl});
      if (mid) chk(out_valid, {"R9 next bit of window ", ctx}, out_valid, 1);
      chk(!(cfg_ready && dec_ready), {"R10 ready exclusion ", ctx}, cfg_ready, 0);
      if (!cfg_done) chk(!dec_ready, {"R10 input before config ", ctx}, dec_ready, 0);
      else chk(!cfg_ready, {"R1 busy config closed ", ctx}, cfg_ready, 0);
      mid = 0;
      if (out_valid && out_ready) begin
        if (oi >= n) chk(0, {"R5 extra bit ", ctx}, oi, n);
        else begin
          chk(out_bit == eb[oi], fw[oi] ? {"R6 final span bit ", ctx} : {"R3,R4 window bit ", ctx},
              out_bit, eb[oi]);
          chk(out_last == (oi == n - 1), {"R7 last flag ", ctx}, out_last, oi == n - 1);
          mid = !we[oi];
          if (oi == n - 1) done = 1;
          oi++;
        end
      end
      hold = out_valid && !out_ready;
      hb = out_bit; hl = out_last;

      if (in_acc) begin ii++; in_acc = 0; end
      if (ii < n) begin
        if (!dec_valid) dec_valid = rnd ? ($urandom % 4 != 0) : 1'b1;
        dec_data = dq[ii];
        dec_last = (ii == n - 1);
      end else begin
        dec_valid = 0; dec_last = 0;
      end
      if (dec_valid && dec_ready) in_acc = 1;
    end
    dec_valid = 0; dec_last = 0;
    @(negedge clk);
    chk(cfg_ready, {"R1 config reopens ", ctx}, cfg_ready, 1);
    chk(!out_valid, {"R5 nothing after block ", ctx}, out_valid, 0);
    chk(oi == n, {"R11 bits per block ", ctx}, oi, n);
  endtask

  initial begin
    rst_n = 0; cfg_valid = 0; cfg_data = '0; dec_valid = 0; dec_data = '0;
    dec_last = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cfg_ready, "R1 reset config ready", cfg_ready, 1);
    chk(!dec_ready, "R10 reset input closed", dec_ready, 0);
    chk(!out_valid, "R5 reset no output", out_valid, 0);
    run_block({16'd8,   16'd6},   40, 0, "R4 full windows");
    run_block({16'd5,   16'd10},  23, 1, "R6 short tail");
    run_block({16'd16,  16'd0},   16, 0, "R4 zero acquisition");
    run_block({16'd0,   16'd3},    7, 1, "R2 zero window");
    run_block({16'd100, 16'd200}, 50, 1, "R2 over max");
    run_block({16'd4,   16'd2},    1, 0, "R6 one step");
    run_block({16'd16,  16'd16},  70, 1, "R11 max lengths");
    run_block({16'd3,   16'd9},   31, 1, "R11 new lengths");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule